// File: doc/BRIEF.md
# Parallel Bit Extract/Deposit Unit

This unit rearranges the bits of one operand under the control of a run-time mask. The operand width is 32 or 64 bits and is chosen separately for each operation. In extract mode, every source bit whose mask bit is set is gathered. These bits are packed into the low end of the result, keeping their relative order, and the bits above them are zero. In deposit mode, the lowest source bits are taken in turn and placed at the set mask positions, from the low end upward. Every position whose mask bit is clear reads zero. Bit 0 is the least significant bit throughout.

The unit works iteratively and visits one mask bit per clock. A start pulse latches the operands and the two selects. While the operation runs, the unit reports busy, and a start seen in that time has no effect. When the operation ends, a one-cycle done strobe marks the new value on the registered result port. The result port then holds that value until the next operation completes.

Top module: `bitperm_unit`

## Requirements
- R1: Extract (op_i=0) places source bit i for each set mask bit i into the result, in increasing i, starting at result bit 0. All result bits at or above the mask population count are 0. Example (8-bit view): source 8'b1011_0110 with mask 8'b0110_0101 gives 8'h06.
- R2: Deposit (op_i=1) places source bit j at the position of the (j+1)-th set mask bit, counted from bit 0. Every position whose mask bit is clear is 0. With the same example inputs, the result is 8'h24.
- R3: With wide_i=0 (32-bit mode), bits 63:32 of src_i and mask_i have no effect, and bits 63:32 of result_o are 0. With wide_i=1, all 64 bits take part.
- R4: An all-zero mask gives an all-zero result for both operations. A mask whose active-width bits are all ones returns the source, limited to the active width, for both operations.
- R5: When start_i is sampled high while busy_o is low, done_o is high for exactly one cycle, 32 clock edges later in 32-bit mode or 64 edges later in 64-bit mode. result_o carries the result in that same cycle.
- R6: A start_i pulse while busy_o is high is ignored. The running operation keeps its operands, its result and its done timing.
- R7: After the synchronous active-high reset, busy_o, done_o and result_o are all 0.
- R8: result_o changes only in a cycle in which done_o is high. Between completions it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Latches the operands and begins an operation when idle |
| op_i | input | 1 | 0 = extract, 1 = deposit |
| wide_i | input | 1 | 0 = 32-bit operation, 1 = 64-bit operation |
| src_i | input | 64 | Source operand |
| mask_i | input | 64 | Selection mask |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle strobe: result_o holds a new result |
| result_o | output | 64 | Registered result |

## Verification
A result is due exactly 32 or 64 clock edges after the edge that accepted the start, depending on the latched width. The bench counts rising edges from that accepting edge and samples done_o and result_o on the falling edge after each one. It requires the first strobe at the predicted count and checks that the strobe is low again one cycle later. Retrigger and hold checks sample result_o at the falling edges between strobes, so a late, early or spurious update is seen where it would appear.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;
  typedef enum logic {
    OP_EXTRACT = 1'b0,
    OP_DEPOSIT = 1'b1
  } bp_op_e;
endpackage

// File: rtl/bitperm_ctrl.sv
module bitperm_ctrl #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  localparam int IDX_W   = $clog2(WIDE_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             wide,
  output logic             accept,
  output logic             busy,
  output logic             last,
  output logic             done,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_WIDE   = IDX_W'(WIDE_W - 1);
  localparam logic [IDX_W-1:0] LAST_NARROW = IDX_W'(NARROW_W - 1);

  logic             busy_q;
  logic             done_q;
  logic             wide_q;
  logic [IDX_W-1:0] idx_q;

  assign accept = start && !busy_q;
  assign last   = busy_q && (idx_q == (wide_q ? LAST_WIDE : LAST_NARROW));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wide_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        wide_q <= wide;
        idx_q  <= '0;
      end else if (busy_q) begin
        idx_q <= idx_q + IDX_W'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign idx  = idx_q;
endmodule

// File: rtl/bitperm_path.sv
module bitperm_path
  import bitperm_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  localparam int IDX_W   = $clog2(WIDE_W),
  localparam int CNT_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              busy,
  input  logic              last,
  input  logic [IDX_W-1:0]  idx,
  input  bp_op_e            op,
  input  logic              wide,
  input  logic [WIDE_W-1:0] src,
  input  logic [WIDE_W-1:0] mask,
  output logic [WIDE_W-1:0] result
);
  localparam logic [WIDE_W-1:0] NARROW_LIM =
    {{(WIDE_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [WIDE_W-1:0] lim;
  logic [WIDE_W-1:0] src_q, mask_q, acc_q, acc_nxt, res_q;
  logic [CNT_W-1:0]  ptr_q, ptr_nxt;
  bp_op_e            op_q;

  assign lim = wide ? {WIDE_W{1'b1}} : NARROW_LIM;

  // one mask position per cycle; ptr counts set mask bits seen so far
  always_comb begin
    acc_nxt = acc_q;
    ptr_nxt = ptr_q;
    if (mask_q[idx]) begin
      ptr_nxt = ptr_q + CNT_W'(1);
      if (op_q == OP_EXTRACT) acc_nxt[ptr_q[IDX_W-1:0]] = src_q[idx];
      else                    acc_nxt[idx] = src_q[ptr_q[IDX_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      mask_q <= '0;
      acc_q  <= '0;
      ptr_q  <= '0;
      res_q  <= '0;
      op_q   <= OP_EXTRACT;
    end else if (accept) begin
      src_q  <= src & lim;
      mask_q <= mask & lim;
      acc_q  <= '0;
      ptr_q  <= '0;
      op_q   <= op;
    end else if (busy) begin
      acc_q <= acc_nxt;
      ptr_q <= ptr_nxt;
      if (last) res_q <= acc_nxt;
    end
  end

  assign result = res_q;
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
  import bitperm_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              op_i,
  input  logic              wide_i,
  input  logic [WIDE_W-1:0] src_i,
  input  logic [WIDE_W-1:0] mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WIDE_W-1:0] result_o
);
  localparam int IDX_W = $clog2(WIDE_W);

  logic             accept, busy, last;
  logic [IDX_W-1:0] idx;

  bitperm_ctrl #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start_i),
    .wide   (wide_i),
    .accept (accept),
    .busy   (busy),
    .last   (last),
    .done   (done_o),
    .idx    (idx)
  );

  bitperm_path #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_path (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .busy   (busy),
    .last   (last),
    .idx    (idx),
    .op     (bp_op_e'(op_i)),
    .wide   (wide_i),
    .src    (src_i),
    .mask   (mask_i),
    .result (result_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/bitperm_unit_chk.sv
module bitperm_unit_chk #(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              op_i,
  input logic              wide_i,
  input logic [WIDE_W-1:0] src_i,
  input logic [WIDE_W-1:0] mask_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [WIDE_W-1:0] result_o
);
  localparam int CW = $clog2(WIDE_W + 1) + 1;
  localparam logic [WIDE_W-1:0] NLIM = {{(WIDE_W - NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic              wide_l, op_l;
  logic [WIDE_W-1:0] src_l, mask_l;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_l <= 1'b0; op_l <= 1'b0; src_l <= '0; mask_l <= '0; cnt <= '0;
    end else if (start_i && !busy_o) begin
      wide_l <= wide_i;
      op_l   <= op_i;
      src_l  <= src_i  & (wide_i ? {WIDE_W{1'b1}} : NLIM);
      mask_l <= mask_i & (wide_i ? {WIDE_W{1'b1}} : NLIM);
      cnt    <= '0;
    end else if (busy_o) begin
      cnt <= cnt + CW'(1);
    end
  end

  a_r1_extract_ones: assert property (@(posedge clk) disable iff (rst)
    (done_o && !op_l) |-> ($countones(result_o) == $countones(src_l & mask_l)));
  a_r1_extract_packed: assert property (@(posedge clk) disable iff (rst)
    (done_o && !op_l) |-> ((result_o >> $countones(mask_l)) == '0));
  a_r2_deposit_in_mask: assert property (@(posedge clk) disable iff (rst)
    (done_o && op_l) |-> ((result_o & ~mask_l) == '0));
  a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (done_o && !wide_l) |-> ((result_o & ~NLIM) == '0));
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (cnt == (wide_l ? CW'(WIDE_W) : CW'(NARROW_W))));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r6_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    (start_i && busy_o) |=> (busy_o || done_o));
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));
endmodule

bind bitperm_unit bitperm_unit_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .wide_i(wide_i),
  .src_i(src_i), .mask_i(mask_i), .busy_o(busy_o), .done_o(done_o),
  .result_o(result_o)
);

// File: tb/bitperm_unit_bench.sv
module bitperm_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, op_i = 1'b0, wide_i = 1'b0;
  logic [63:0] src_i = '0, mask_i = '0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bitperm_unit u_bitperm_unit (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .wide_i(wide_i),
    .src_i(src_i), .mask_i(mask_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o)
  );

  function automatic logic [63:0] ref_perm(input logic op, input logic wide,
                                           input logic [63:0] s, input logic [63:0] m);
    logic [63:0] r = '0;
    int k = 0;
    int w = wide ? 64 : 32;
    for (int i = 0; i < w; i++) begin
      if (m[i]) begin
        if (!op) r[k] = s[i];
        else     r[i] = s[k];
        k++;
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // runs one operation; poke>0 pulses a second start at that busy cycle (R6)
  task automatic run_op(input string req, input logic op, input logic wide,
                        input logic [63:0] s, input logic [63:0] m, input int poke);
    int cyc = 0;
    @(negedge clk);
    start_i = 1'b1; op_i = op; wide_i = wide; src_i = s; mask_i = m;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done_o) break;
      if (cyc > 200) begin
        checks++; fails++;
        $display("FAIL R5: actual no done expected done within 64");
        break;
      end
      if (poke > 0 && cyc == poke) begin
        start_i = 1'b1; op_i = ~op; wide_i = ~wide; src_i = ~s; mask_i = ~m;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    chk("R5 latency", 64'(cyc), wide ? 64 : 32);
    chk(req, result_o, ref_perm(op, wide, s, m));
    @(negedge clk);
    chk("R5 single pulse", {63'd0, done_o}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 busy", {63'd0, busy_o}, 64'd0);
    chk("R7 done", {63'd0, done_o}, 64'd0);
    chk("R7 result", result_o, 64'd0);
    rst = 1'b0;

    // R1 / R2 worked example
    run_op("R1 example", 1'b0, 1'b1, 64'hB6, 64'h65, 0);
    chk("R1 example value", result_o, 64'h06);
    run_op("R2 example", 1'b1, 1'b1, 64'hB6, 64'h65, 0);
    chk("R2 example value", result_o, 64'h24);

    // R4 corner masks
    for (int w = 0; w < 2; w++) begin
      for (int o = 0; o < 2; o++) begin
        run_op("R4 zero mask", o[0], w[0], 64'hDEAD_BEEF_1234_5678, 64'd0, 0);
        chk("R4 zero value", result_o, 64'd0);
        run_op("R4 ones mask", o[0], w[0], 64'hDEAD_BEEF_1234_5678, '1, 0);
        chk("R4 ones value", result_o,
            w[0] ? 64'hDEAD_BEEF_1234_5678 : 64'h0000_0000_1234_5678);
      end
    end

    // R3 narrow mode with junk in the upper halves
    run_op("R3 narrow extract", 1'b0, 1'b0, 64'hFFFF_FFFF_0F0F_0F0F, 64'hFFFF_FFFF_00FF_FF00, 0);
    chk("R3 upper zero ext", {32'd0, result_o[63:32]}, 64'd0);
    run_op("R3 narrow deposit", 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_AAAA_8000_0001, 0);
    chk("R3 deposit value", result_o, 64'h0000_0000_8000_0001);

    // R6 retrigger while busy, in both widths
    run_op("R6 ignored start", 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hF0F0_0FF0_1248_8421, 5);
    run_op("R6 ignored start narrow", 1'b1, 1'b0, 64'h0000_0000_0000_A5C3, 64'h0000_0000_F00F_0F0F, 20);

    // R8 hold between completions
    held = result_o;
    repeat (10) @(negedge clk);
    chk("R8 hold", result_o, held);

    // random mix for R1 / R2 / R3
    for (int n = 0; n < 60; n++) begin
      logic o, w;
      logic [63:0] s, m;
      o = 1'($urandom);
      w = 1'($urandom);
      s = {$urandom, $urandom};
      case (n % 4)
        0: m = {$urandom, $urandom};
        1: m = {$urandom, $urandom} & {$urandom, $urandom};
        2: m = {$urandom, $urandom} | {$urandom, $urandom};
        default: m = 64'd1 << ($urandom % 64);
      endcase
      run_op(o ? "R2 random" : "R1 random", o, w, s, m, 0);
      if (!w) chk("R3 random upper zero", {32'd0, result_o[63:32]}, 64'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule